// File: doc/BRIEF.md
# Boot-time clock configuration sequencer

This block runs once after power-up and decides how the board's clock buffers are set up before anything else on the chip may run. It looks at which add-on clock module is fitted and reads that module's switch setting. It then asks an external configuration writer to load one of seven buffer configurations. The writer performs the serial register accesses itself. The sequencer only sees a request/done handshake and does not take part in those accesses.

For the PLL-style module with a nonzero switch code, the sequencer first waits for the PLL's reference clock to show activity. It then loads the configuration and waits for the PLL to report lock. On every path, the reset held on the on-chip clock-management circuits is released only at the very end. After that the sequencer halts and ignores every input until the next reset. Both status inputs are asynchronous and pass through a two-stage synchronizer.

Top module: `clkboot_seq`

## Requirements
- R1: While `rst_n` is low, `mgr_rst` is 1, `cfg_req` is 0, `halted` is 0 and `cfg_sel` is 0. `mgr_rst` stays 1 until the sequence finishes, and at that point it falls in the same cycle that `halted` rises.
- R2: With neither module fitted, the sequencer selects code 0 (no module), requests a load, and finishes one edge after `cfg_done` is seen.
- R3: With the connector-type module fitted, `conn_sw` values 00, 01, 10 and 11 select codes 0, 1, 2 and 3. The sequencer finishes right after the load, with no wait on status inputs.
- R4: With the PLL module fitted, only bits [1:0] of `pll_sw` are decoded. Higher bits have no effect on the code chosen.
- R5: On the PLL path with switch bits 00, code 0 is loaded and the sequencer finishes after the load, whatever the reference and lock statuses are.
- R6: On the PLL path with switch bits 01, 10 or 11, no load is requested until the synchronized reference-activity status is 1. The codes loaded are then 4, 5 and 6 respectively.
- R7: On the PLL path with a nonzero switch code, after `cfg_done` the sequencer keeps `mgr_rst` at 1 until the synchronized lock status is 1, and only then finishes.
- R8: `cfg_sel` does not change while `cfg_req` is 1. `cfg_req` falls on the edge after the one at which `cfg_done` is sampled high.
- R9: Presence is decided in priority order: no module first, then the connector module, then the PLL module. When both flags are set, the connector path is taken.
- R10: Presence flags and switch values are captured only on the first clock edge after reset release. Later changes do not alter the path or `cfg_sel`.
- R11: Once halted, the outputs stay at `halted`=1, `mgr_rst`=0, `cfg_req`=0 with `cfg_sel` unchanged, whatever the inputs do, until reset.
- R12: A rise on `refclk_active` or `pll_locked` takes effect on the third rising clock edge after it. That edge is where a pending load request starts or the lock wait finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| conn_fitted | input | 1 | Connector-type clock module present |
| pll_fitted | input | 1 | PLL-type clock module present |
| conn_sw | input | 2 | Switch setting of the connector-type module |
| pll_sw | input | PLL_SW_W | Switch setting of the PLL module; only bits [1:0] used |
| refclk_active | input | 1 | PLL reference clock seen toggling (asynchronous) |
| pll_locked | input | 1 | PLL lock status (asynchronous) |
| cfg_done | input | 1 | Configuration writer finished the requested load |
| cfg_sel | output | 3 | Configuration code: 0 none, 1-3 connector A-C, 4-6 PLL A-C |
| cfg_req | output | 1 | Load request to the configuration writer |
| mgr_rst | output | 1 | Reset to the clock-management circuits, active high |
| halted | output | 1 | Sequence finished |

## Verification
On every path except the PLL wait path, `cfg_req` is due one rising edge after reset release. `halted` is due one edge after `cfg_done` is sampled. On the PLL wait path, the request and the halt each come three edges after the status input rises. The bench changes inputs on falling edges and samples on the falling edge that follows the edge where a result is due. It also checks that the result is still absent on the falling edge before. Wait windows are held several extra cycles to show that nothing moves early.

// File: rtl/clkboot_pkg.sv
package clkboot_pkg;

  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_NOMOD    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PLL_BASE = 3'd3;

  typedef enum logic [1:0] {
    PATH_NOMOD,
    PATH_CONN,
    PATH_PLL_DIRECT,
    PATH_PLL_WAIT
  } path_e;

  typedef enum logic [2:0] {
    ST_SAMPLE,
    ST_WAIT_REF,
    ST_LOAD,
    ST_WAIT_LOCK,
    ST_HALT
  } state_e;

endpackage

// File: rtl/clkboot_sync.sv
module clkboot_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkboot_select.sv
module clkboot_select
  import clkboot_pkg::*;
#(
  parameter int PLL_SW_W = 4
) (
  input  logic                conn_fitted,
  input  logic                pll_fitted,
  input  logic [1:0]          conn_sw,
  input  logic [PLL_SW_W-1:0] pll_sw,
  output path_e               path,
  output logic [SEL_W-1:0]    sel
);

  logic [1:0] pll_code;

  assign pll_code = pll_sw[1:0];

  if (PLL_SW_W > 2) begin : g_hi_bits
    logic unused_pll_hi;
    assign unused_pll_hi = ^pll_sw[PLL_SW_W-1:2];
  end

  always_comb begin
    path = PATH_NOMOD;
    sel  = SEL_NOMOD;
    if (!conn_fitted && !pll_fitted) begin
      path = PATH_NOMOD;
      sel  = SEL_NOMOD;
    end else if (conn_fitted) begin
      path = PATH_CONN;
      sel  = {1'b0, conn_sw};
    end else if (pll_code == 2'b00) begin
      path = PATH_PLL_DIRECT;
      sel  = SEL_NOMOD;
    end else begin
      path = PATH_PLL_WAIT;
      sel  = SEL_PLL_BASE + {1'b0, pll_code};
    end
  end

endmodule

// File: rtl/clkboot_fsm.sv
module clkboot_fsm
  import clkboot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  path_e            path_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             ref_ok,
  input  logic             lock_ok,
  input  logic             cfg_done,
  output logic [SEL_W-1:0] cfg_sel,
  output logic             cfg_req,
  output logic             mgr_rst,
  output logic             halted
);

  state_e           state_q, state_d;
  path_e            path_q;
  logic [SEL_W-1:0] sel_q;
  logic             cap_en;

  assign cap_en = (state_q == ST_SAMPLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_SAMPLE:    state_d = (path_in == PATH_PLL_WAIT) ? ST_WAIT_REF : ST_LOAD;
      ST_WAIT_REF:  if (ref_ok) state_d = ST_LOAD;
      ST_LOAD:      if (cfg_done)
                      state_d = (path_q == PATH_PLL_WAIT) ? ST_WAIT_LOCK : ST_HALT;
      ST_WAIT_LOCK: if (lock_ok) state_d = ST_HALT;
      ST_HALT:      state_d = ST_HALT;
      default:      state_d = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SAMPLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_q <= PATH_NOMOD;
      sel_q  <= SEL_NOMOD;
    end else if (cap_en) begin
      path_q <= path_in;
      sel_q  <= sel_in;
    end
  end

  assign cfg_sel = sel_q;
  assign cfg_req = (state_q == ST_LOAD);
  assign mgr_rst = (state_q != ST_HALT);
  assign halted  = (state_q == ST_HALT);

  a_r8_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done) |=> (cfg_req && $stable(cfg_sel)));

  a_r8_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_done) |=> !cfg_req);

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mgr_rst && !cfg_req && $stable(cfg_sel)));

  a_r6_ref_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_req) && path_q == PATH_PLL_WAIT) |-> $past(ref_ok));

  a_r7_lock_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mgr_rst) && path_q == PATH_PLL_WAIT) |-> $past(lock_ok));

  a_r2_release_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mgr_rst) && path_q != PATH_PLL_WAIT) |-> $past(cfg_done && cfg_req));

endmodule

// File: rtl/clkboot_seq.sv
module clkboot_seq
  import clkboot_pkg::*;
#(
  parameter int PLL_SW_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conn_fitted,
  input  logic                pll_fitted,
  input  logic [1:0]          conn_sw,
  input  logic [PLL_SW_W-1:0] pll_sw,
  input  logic                refclk_active,
  input  logic                pll_locked,
  input  logic                cfg_done,
  output logic [SEL_W-1:0]    cfg_sel,
  output logic                cfg_req,
  output logic                mgr_rst,
  output logic                halted
);

  localparam int STAT_W = 2;

  logic [STAT_W-1:0] stat_raw, stat_sync;
  path_e             path_dec;
  logic [SEL_W-1:0]  sel_dec;

  assign stat_raw = {pll_locked, refclk_active};

  clkboot_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (stat_raw),
    .q     (stat_sync)
  );

  clkboot_select #(.PLL_SW_W(PLL_SW_W)) u_select (
    .conn_fitted (conn_fitted),
    .pll_fitted  (pll_fitted),
    .conn_sw     (conn_sw),
    .pll_sw      (pll_sw),
    .path        (path_dec),
    .sel         (sel_dec)
  );

  clkboot_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .path_in  (path_dec),
    .sel_in   (sel_dec),
    .ref_ok   (stat_sync[0]),
    .lock_ok  (stat_sync[1]),
    .cfg_done (cfg_done),
    .cfg_sel  (cfg_sel),
    .cfg_req  (cfg_req),
    .mgr_rst  (mgr_rst),
    .halted   (halted)
  );

endmodule

// File: tb/clkboot_seq_bench.sv
module clkboot_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       conn_fitted, pll_fitted;
  logic [1:0] conn_sw;
  logic [3:0] pll_sw;
  logic       refclk_active, pll_locked, cfg_done;
  logic [2:0] cfg_sel;
  logic       cfg_req, mgr_rst, halted;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit over   = 1'b0;

  always #2 clk = ~clk;

  clkboot_seq #(.PLL_SW_W(4), .SYNC_STAGES(2)) u_clkboot_seq (
    .clk(clk), .rst_n(rst_n), .conn_fitted(conn_fitted), .pll_fitted(pll_fitted),
    .conn_sw(conn_sw), .pll_sw(pll_sw), .refclk_active(refclk_active),
    .pll_locked(pll_locked), .cfg_done(cfg_done), .cfg_sel(cfg_sel),
    .cfg_req(cfg_req), .mgr_rst(mgr_rst), .halted(halted)
  );

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(bit cf, bit pf, logic [1:0] cs, logic [3:0] ps);
    @(negedge clk);
    rst_n = 1'b0;
    conn_fitted = cf; pll_fitted = pf; conn_sw = cs; pll_sw = ps;
    refclk_active = 1'b0; pll_locked = 1'b0; cfg_done = 1'b0;
    step(3);
    check("R1 reset mgr_rst", mgr_rst, 1);
    check("R1 reset cfg_req", cfg_req, 0);
    check("R1 reset halted", halted, 0);
    check("R1 reset cfg_sel", cfg_sel, 0);
    rst_n = 1'b1;
  endtask

  task automatic ack();
    cfg_done = 1'b1;
    step(1);
    cfg_done = 1'b0;
  endtask

  task automatic expect_end(string rq);
    check({rq, " halted"}, halted, 1);
    check({"R1 ", rq, " mgr_rst released"}, mgr_rst, 0);
    check({"R8 ", rq, " cfg_req dropped"}, cfg_req, 0);
  endtask

  task automatic t_nomod();
    start(0, 0, 2'b11, 4'hF);
    step(1);
    check("R2 cfg_req", cfg_req, 1);
    check("R2 cfg_sel", cfg_sel, 0);
    check("R1 mgr_rst held", mgr_rst, 1);
    ack();
    expect_end("R2");
  endtask

  task automatic t_conn(logic [1:0] cs, int exp);
    start(1, 0, cs, 4'h0);
    step(1);
    check("R3 cfg_req", cfg_req, 1);
    check("R3 cfg_sel", cfg_sel, exp);
    step(2);
    check("R8 req held", cfg_req, 1);
    check("R8 sel held", cfg_sel, exp);
    ack();
    expect_end("R3");
  endtask

  task automatic t_pll_direct();
    start(0, 1, 2'b01, 4'b1100);
    step(1);
    check("R4 R5 cfg_req", cfg_req, 1);
    check("R4 R5 cfg_sel", cfg_sel, 0);
    ack();
    expect_end("R5");
  endtask

  task automatic t_pll(logic [3:0] ps, int exp);
    start(0, 1, 2'b00, ps);
    step(5);
    check("R6 no req before ref", cfg_req, 0);
    check("R6 mgr_rst held", mgr_rst, 1);
    pll_sw = ~ps;
    refclk_active = 1'b1;
    step(2);
    check("R12 req not yet", cfg_req, 0);
    step(1);
    check("R12 R6 cfg_req", cfg_req, 1);
    check("R6 R4 R10 cfg_sel", cfg_sel, exp);
    ack();
    check("R8 req dropped", cfg_req, 0);
    check("R7 not halted before lock", halted, 0);
    step(4);
    check("R7 mgr_rst before lock", mgr_rst, 1);
    pll_locked = 1'b1;
    step(2);
    check("R12 halt not yet", halted, 0);
    step(1);
    check("R12 R7 halted", halted, 1);
    check("R7 mgr_rst released", mgr_rst, 0);
  endtask

  task automatic t_priority();
    start(1, 1, 2'b10, 4'b0001);
    step(1);
    check("R9 cfg_req", cfg_req, 1);
    check("R9 cfg_sel", cfg_sel, 2);
    ack();
    expect_end("R9");
  endtask

  task automatic t_sample_once();
    start(1, 0, 2'b01, 4'h0);
    step(1);
    conn_fitted = 1'b0; pll_fitted = 1'b1; conn_sw = 2'b11; pll_sw = 4'b0011;
    step(2);
    check("R10 req kept", cfg_req, 1);
    check("R10 sel kept", cfg_sel, 1);
    ack();
    expect_end("R10");
  endtask

  task automatic t_halt_ignore();
    start(1, 0, 2'b11, 4'h0);
    step(1);
    ack();
    for (int i = 0; i < 8; i++) begin
      cfg_done = ~cfg_done; refclk_active = ~refclk_active; pll_locked = ~pll_locked;
      conn_fitted = ~conn_fitted; pll_fitted = i[0]; conn_sw = i[1:0]; pll_sw = i[3:0];
      step(1);
      check("R11 halted", halted, 1);
      check("R11 mgr_rst", mgr_rst, 0);
      check("R11 cfg_req", cfg_req, 0);
      check("R11 cfg_sel", cfg_sel, 3);
    end
    cfg_done = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !over) begin
      over = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    conn_fitted = 1'b0; pll_fitted = 1'b0; conn_sw = 2'b00; pll_sw = 4'h0;
    refclk_active = 1'b0; pll_locked = 1'b0; cfg_done = 1'b0;
    t_nomod();
    t_conn(2'b00, 0);
    t_conn(2'b01, 1);
    t_conn(2'b10, 2);
    t_conn(2'b11, 3);
    t_pll_direct();
    t_pll(4'b0001, 4);
    t_pll(4'b1010, 5);
    t_pll(4'b0111, 6);
    t_priority();
    t_sample_once();
    t_halt_ignore();
    over = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule